// File: doc/BRIEF.md
# Quadrature Rotary Knob Interface

This block turns the two phase contacts of a mechanical rotary knob into counted rotation steps. Each phase input is brought into the clock domain by a two-stage synchroniser. It then passes through a chatter filter that accepts a new level only after the level has held for a programmed number of sample ticks. The two filtered levels form a two-bit Gray position. Every legal step from one position to the next is reported as a clockwise (up) or counter-clockwise (down) event.

Events feed three pieces of state. A three-bit contact counter saturates at both ends. A direction bit records the sense of the most recent step. An interrupt request stays raised until the host stops it. The host clears all three by issuing the stop command while chip-select is low. The sample tick lets the integrator set the chatter window in real time, for example about 1 ms per accepted level, independently of the system clock.

Top module: `quad_knob_if`

## Requirements
- R1: After reset the counter reads 000, the direction bit reads 0 and the interrupt request is low.
- R2: Phase positions are coded AB = 00, 10, 11, 01 in clockwise order. A filtered step forward in this order is an up event, and the counter increases by one.
- R3: A filtered step backward in that order (00, 01, 11, 10) is a down event, and the counter decreases by one.
- R4: The counter holds at 111 on up events and does not wrap.
- R5: The counter holds at 000 on down events and does not wrap.
- R6: A new level on a phase input is accepted only after it has differed from the accepted level for HOLD_TICKS consecutive sample ticks. A shorter excursion, or any stretch with the tick held low, causes no event.
- R7: A down event sets the direction bit to 1 (counter-clockwise). An up event sets it to 0 (clockwise).
- R8: Any up or down event raises the interrupt request, and it stays high until a clear.
- R9: A cycle with the stop command high and chip-select low clears the counter, the direction bit and the interrupt request. The stop command with chip-select high changes nothing.
- R10: If both phases are accepted as changed on the same cycle, no event is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Sample tick for the chatter filters |
| phase_a_i | input | 1 | Raw knob phase A contact |
| phase_b_i | input | 1 | Raw knob phase B contact |
| stop_cmd_i | input | 1 | Stop command strobe from the host interface |
| csel_i | input | 1 | Chip-select level; the clear takes effect only while low |
| dir_o | output | 1 | Direction bit: 0 clockwise, 1 counter-clockwise |
| count_o | output | 3 | Saturating contact counter; bit 0 is the LSB |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong accepted phase level in either filter shows within one clock as a spurious or missing event. The counter then moves the wrong way or stays put, and the interrupt rises without cause. A stale previous-position register gives a second event or a reversed direction on the following step. A counter that wraps shows on the very next event at a boundary, as 111 turning into 000 or the reverse. These are the points where the directed sequences sample the outputs, after the synchroniser and filter latency has passed.

// File: rtl/knob_pkg.sv
package knob_pkg;
  typedef logic [1:0] knob_pos_t;

  // Gray position of the phase pair; clockwise order 00,10,11,01
  function automatic knob_pos_t pos_of(input logic a, input logic b);
    knob_pos_t p;
    unique case ({a, b})
      2'b00:   p = 2'd0;
      2'b10:   p = 2'd1;
      2'b11:   p = 2'd2;
      default: p = 2'd3;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/knob_deglitch.sv
module knob_deglitch #(
  parameter int HOLD_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic level_o
);
  localparam int RW = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(HOLD_TICKS - 1);

  logic [1:0]    sync_q;
  logic [RW-1:0] run_q, run_d;
  logic          level_q, level_d;

  always_comb begin
    run_d   = run_q;
    level_d = level_q;
    if (tick_i) begin
      if (sync_q[1] != level_q) begin
        if (run_q == RUN_LAST) begin
          level_d = sync_q[1];
          run_d   = '0;
        end else begin
          run_d = run_q + RW'(1);
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      run_q   <= '0;
      level_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], raw_i};
      run_q   <= run_d;
      level_q <= level_d;
    end
  end

  assign level_o = level_q;

  AST_NO_UNTICKED_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(level_q)); // R6
  AST_ACCEPT_FOLLOWS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> (level_q == $past(sync_q[1]))); // R6
endmodule

// File: rtl/knob_step_decode.sv
module knob_step_decode
  import knob_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic up_o,
  output logic dn_o
);
  knob_pos_t cur_pos, prev_q, diff;

  always_comb begin
    cur_pos = pos_of(a_i, b_i);
    diff    = cur_pos - prev_q;
    up_o    = (diff == 2'd1);
    dn_o    = (diff == 2'd3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'd0;
    else         prev_q <= cur_pos;
  end

  AST_DOUBLE_STEP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_i != $past(a_i)) && (b_i != $past(b_i))) |-> (!up_o && !dn_o)); // R10
endmodule

// File: rtl/knob_tally.sv
module knob_tally #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d, irq_q, irq_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    irq_d = irq_q;
    if (clr_i) begin
      cnt_d = '0;
      dir_d = 1'b0;
      irq_d = 1'b0;
    end else if (up_i) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
      dir_d = 1'b0;
      irq_d = 1'b1;
    end else if (dn_i) begin
      if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
      dir_d = 1'b1;
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      irq_q <= irq_d;
    end
  end

  assign count_o = cnt_q;
  assign dir_o   = dir_q;
  assign irq_o   = irq_q;

  AST_EVENT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_i && dn_i)); // R2
  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && !clr_i && cnt_q != CNT_MAX) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
  AST_DN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !clr_i && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && !clr_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !clr_i && cnt_q == '0) |=> (cnt_q == '0)); // R5
  AST_DIR_ON_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !clr_i) |=> dir_q); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q); // R8
  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !dir_q && !irq_q)); // R9
endmodule

// File: rtl/quad_knob_if.sv
module quad_knob_if #(
  parameter int HOLD_TICKS = 16,
  parameter int CNT_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             phase_a_i,
  input  logic             phase_b_i,
  input  logic             stop_cmd_i,
  input  logic             csel_i,
  output logic             dir_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  localparam int NPH = 2;

  logic [1:0]     rst_sync_q;
  logic           rst_n_int;
  logic [NPH-1:0] raw_ph, lvl_ph;
  logic           up_ev, dn_ev, clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign raw_ph = {phase_b_i, phase_a_i};
  assign clr    = stop_cmd_i && !csel_i;

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    knob_deglitch #(.HOLD_TICKS(HOLD_TICKS)) filt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_n_int),
      .tick_i (tick_i),
      .raw_i  (raw_ph[g]),
      .level_o(lvl_ph[g])
    );
  end

  knob_step_decode dec_i (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .a_i   (lvl_ph[0]),
    .b_i   (lvl_ph[1]),
    .up_o  (up_ev),
    .dn_o  (dn_ev)
  );

  knob_tally #(.CNT_W(CNT_W)) tally_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .up_i   (up_ev),
    .dn_i   (dn_ev),
    .clr_i  (clr),
    .count_o(count_o),
    .dir_o  (dir_o),
    .irq_o  (irq_o)
  );

  AST_STOP_WITH_CS_HIGH_INERT: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (stop_cmd_i && csel_i && !up_ev && !dn_ev) |=> ($stable(count_o) && $stable(dir_o) && $stable(irq_o))); // R9
endmodule

// File: tb/quad_knob_if_tb_top.sv
module quad_knob_if_tb_top;
  localparam int HOLD = 16;
  localparam int SETTLE = 30;

  logic       clk = 1'b0;
  logic       rst_n, tick, pa, pb, stop_cmd, csel;
  logic       dir;
  logic [2:0] count;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  int pos = 0;
  int m_cnt = 0;
  int m_dir = 0;
  int m_irq = 0;

  always #10 clk = ~clk;

  quad_knob_if #(.HOLD_TICKS(HOLD), .CNT_W(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .phase_a_i(pa), .phase_b_i(pb),
    .stop_cmd_i(stop_cmd), .csel_i(csel), .dir_o(dir), .count_o(count), .irq_o(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " count"}, int'(count), m_cnt);
    chk({req, " dir"}, int'(dir), m_dir);
    chk({req, " irq"}, int'(irq), m_irq);
  endtask

  task automatic drive_pos(input int p);
    case (p & 3)
      0: begin pa = 1'b0; pb = 1'b0; end
      1: begin pa = 1'b1; pb = 1'b0; end
      2: begin pa = 1'b1; pb = 1'b1; end
      default: begin pa = 1'b0; pb = 1'b1; end
    endcase
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one knob step; cw=1 forward in 00,10,11,01
  task automatic step(input bit cw, input string req);
    pos = cw ? (pos + 1) & 3 : (pos + 3) & 3;
    drive_pos(pos);
    wait_cyc(SETTLE);
    if (cw) begin
      if (m_cnt < 7) m_cnt++;
      m_dir = 0;
    end else begin
      if (m_cnt > 0) m_cnt--;
      m_dir = 1;
    end
    m_irq = 1;
    chk_all(req);
  endtask

  task automatic do_stop(input logic cs, input string req);
    csel = cs; stop_cmd = 1'b1;
    wait_cyc(1);
    stop_cmd = 1'b0; csel = 1'b1;
    wait_cyc(2);
    if (!cs) begin m_cnt = 0; m_dir = 0; m_irq = 0; end
    chk_all(req);
  endtask

  task automatic t_reset();
    chk_all("R1 reset");
  endtask

  task automatic t_clockwise();
    for (int i = 0; i < 4; i++) step(1'b1, "R2 cw step");
  endtask

  task automatic t_top_sat();
    for (int i = 0; i < 5; i++) step(1'b1, "R4 top saturation");
  endtask

  task automatic t_stop();
    do_stop(1'b1, "R9 stop with cs high");
    do_stop(1'b0, "R9 stop with cs low");
  endtask

  task automatic t_counter_cw();
    step(1'b0, "R5 bottom saturation");
    do_stop(1'b0, "R9 clear after down");
    for (int i = 0; i < 3; i++) step(1'b1, "R2 cw");
    step(1'b0, "R3 ccw");
    step(1'b0, "R3 ccw");
    step(1'b1, "R7 up clears dir");
    step(1'b0, "R7 down sets dir");
  endtask

  task automatic t_chatter();
    // short excursion on A only
    pa = ~pa;
    wait_cyc(5);
    pa = ~pa;
    wait_cyc(SETTLE);
    chk_all("R6 short glitch ignored");
    // valid step presented while tick is low
    tick = 1'b0;
    drive_pos((pos + 1) & 3);
    wait_cyc(3 * SETTLE);
    chk_all("R6 no tick no accept");
    tick = 1'b1;
    wait_cyc(HOLD - 6);
    chk_all("R6 not yet accepted");
    drive_pos(pos);
    wait_cyc(SETTLE);
    chk_all("R6 restored before window");
    step(1'b1, "R6 accepted after window");
  endtask

  task automatic t_double();
    pos = (pos + 2) & 3;
    drive_pos(pos);
    wait_cyc(SETTLE);
    chk_all("R10 double change no event");
    step(1'b1, "R10 step after double change");
  endtask

  task automatic t_irq_hold();
    do_stop(1'b0, "R9 clear before irq test");
    step(1'b0, "R8 irq raised by down");
    wait_cyc(50);
    chk("R8 irq held", int'(irq), 1);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; pa = 1'b0; pb = 1'b0; stop_cmd = 1'b0; csel = 1'b1;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_clockwise();
    t_top_sat();
    t_stop();
    t_counter_cw();
    t_chatter();
    t_double();
    t_irq_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule